// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers interrupt causes from a group of peripheral sources and presents them to a host on a 68000-style asynchronous bus. Each source has a sticky pending flag, an enable bit, a host-assigned priority and an 8-bit vector of its own. Any enabled pending source pulls the shared active-low open-drain request line low. The request stays low until host software clears the flag by reading that source's status.

Several devices can share one request line. They are arbitrated by a daisy chain. The enable-in input tells the unit that no device further up the chain wants service. The enable-out output passes that permission down the chain, and only while this unit is idle. When the host starts an interrupt acknowledge cycle and the unit has the chain's permission, the unit captures its highest-priority enabled source. It then holds that source's vector on the low data byte and asserts the data-transfer acknowledge until the cycle ends. With the default configuration there are nine sources: eight per-channel causes and one shared cause.

All bus inputs are taken to be synchronous to `clk`. The open-drain outputs are modelled as levels, where 1 means released.

Top module: `irq_chain_top`

## Requirements
- R1: A source's pending bit (`pend_o[i]`) is set by the clock edge that samples `cause_i[i]` high. It stays set, including through acknowledge cycles, until a status read clears it.
- R2: A status read (`stat_rd` high with `stat_idx` = i) clears only pending bit i, at that clock edge. A cause for the same source in the same cycle keeps the bit set. An index of `NUM_SRC` or above clears nothing.
- R3: `irq_od_n` is 0 exactly when at least one pending source has its enable bit set. Sources that are pending but disabled do not pull the request.
- R4: `ieo_n` is 0 only when `iei_n` is 0 and the unit has no enabled pending source.
- R5: When a clock edge samples `iack_n` low after it was high, with `iei_n` low and an enabled source pending, the next cycle shows `dtack_n` = 0, `vec_oe` = 1 and `vec_o` = the winner's vector. These hold until an edge samples `iack_n` high, which releases them: `dtack_n` = 1, `vec_oe` = 0 and `vec_o` = 0.
- R6: The winner is the enabled pending source with the largest priority value. Ties go to the lowest source index.
- R7: The vector is captured at the acknowledge start. New causes or a changed priority during the cycle do not change `vec_o`.
- R8: An acknowledge start that sees `iei_n` high, or no enabled pending source, is ignored until the next falling `iack_n`. During that time `dtack_n` stays 1 and `vec_oe` stays 0.
- R9: Reset leaves every pending and enable bit 0, every priority at 0, and the vector of source i at `VEC_BASE + i`.
- R10: A configuration write (`cfg_we` high) updates the entry for source `cfg_idx`, selected by `cfg_kind`:
  - `cfg_kind` = 0 sets the enable bit to `cfg_wdata[0]`.
  - `cfg_kind` = 1 sets the vector to `cfg_wdata`.
  - `cfg_kind` = 2 sets the priority to `cfg_wdata[PRI_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_i | input | NUM_SRC | Interrupt cause per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 enable, 1 vector, 2 priority |
| cfg_idx | input | SRC_W | Source addressed by the write |
| cfg_wdata | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe, clears one pending bit |
| stat_idx | input | SRC_W | Source whose status is read |
| pend_o | output | NUM_SRC | Pending flags |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| iei_n | input | 1 | Daisy-chain enable in, active low |
| irq_od_n | output | 1 | Open-drain request, 0 = pull low |
| ieo_n | output | 1 | Daisy-chain enable out, active low |
| vec_o | output | 8 | Vector on the low data byte |
| vec_oe | output | 1 | Low data byte drive enable |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
A corrupted pending or enable flag shows on `irq_od_n` and `pend_o` one cycle after the cause or write that produced it. A wrong priority or vector entry stays hidden until an acknowledge picks that source, and then it appears as a wrong `vec_o` one cycle after `iack_n` falls. Faults in the acknowledge state appear as a `dtack_n` that never arrives, arrives while the chain is blocked, or does not release one cycle after `iack_n` rises. A capture fault appears as `vec_o` changing in mid-cycle. The sweeps cover every source alone, every pair of sources under distinct priorities, and all sources at once, so a single bad table entry or arbitration term is reached within one acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        CFG_ENABLE = 2'd0,
        CFG_VECTOR = 2'd1,
        CFG_PRIO   = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_chain_pkg::*;
#(
    parameter int          NUM_SRC  = 9,
    parameter int          PRI_W    = 2,
    parameter logic [7:0]  VEC_BASE = 8'h40,
    localparam int         SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                cause_i,
    input  logic                              cfg_we,
    input  logic [1:0]                        cfg_kind,
    input  logic [SRC_W-1:0]                  cfg_idx,
    input  logic [VEC_W-1:0]                  cfg_wdata,
    input  logic                              stat_rd,
    input  logic [SRC_W-1:0]                  stat_idx,
    output logic [NUM_SRC-1:0]                pend_o,
    output logic [NUM_SRC-1:0]                req_o,
    output logic [NUM_SRC-1:0][PRI_W-1:0]     pri_o,
    output logic [NUM_SRC-1:0][VEC_W-1:0]     vec_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]             pend;
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0][PRI_W-1:0]  pri;
        logic [NUM_SRC-1:0][VEC_W-1:0]  vec;
    } bank_t;

    function automatic bank_t bank_reset();
        bank_t r;
        r.pend = '0;
        r.en   = '0;
        r.pri  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            r.vec[i] = VEC_BASE + VEC_W'(i);
        end
        return r;
    endfunction

    bank_t s_d, s_q;
    logic  cfg_hit, stat_hit;
    cfg_kind_e kind;

    assign cfg_hit  = cfg_we  && ({1'b0, cfg_idx}  < (SRC_W+1)'(NUM_SRC));
    assign stat_hit = stat_rd && ({1'b0, stat_idx} < (SRC_W+1)'(NUM_SRC));
    assign kind     = cfg_kind_e'(cfg_kind);

    always_comb begin
        s_d = s_q;
        if (stat_hit) begin
            s_d.pend[stat_idx] = 1'b0;
        end
        s_d.pend = s_d.pend | cause_i;
        if (cfg_hit) begin
            case (kind)
                CFG_ENABLE: s_d.en[cfg_idx]  = cfg_wdata[0];
                CFG_VECTOR: s_d.vec[cfg_idx] = cfg_wdata;
                CFG_PRIO:   s_d.pri[cfg_idx] = cfg_wdata[PRI_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= bank_reset();
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign req_o  = s_q.pend & s_q.en;
    assign pri_o  = s_q.pri;
    assign vec_o  = s_q.vec;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int NUM_SRC = 9,
    parameter int PRI_W   = 2,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRI_W-1:0]  pri_i,
    output logic                           any_o,
    output logic [SRC_W-1:0]               win_o
);
    logic             found;
    logic [PRI_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        win_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!found || (pri_i[i] > best))) begin
                found = 1'b1;
                best  = pri_i[i];
                win_o = SRC_W'(i);
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl
    import irq_chain_pkg::*;
#(
    parameter int NUM_SRC = 9,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iack_n,
    input  logic                          iei_n,
    input  logic                          any_req,
    input  logic [SRC_W-1:0]              win_idx,
    input  logic [NUM_SRC-1:0][VEC_W-1:0] vec_tbl,
    output logic [VEC_W-1:0]              vec_o,
    output logic                          vec_oe,
    output logic                          dtack_n
);
    typedef struct packed {
        logic             iack_prev;
        logic             active;
        logic [VEC_W-1:0] vec;
    } ack_t;

    ack_t a_d, a_q;
    logic start;

    assign start = a_q.iack_prev && !iack_n && !iei_n && any_req;

    always_comb begin
        a_d           = a_q;
        a_d.iack_prev = iack_n;
        if (iack_n) begin
            a_d.active = 1'b0;
        end else if (start) begin
            a_d.active = 1'b1;
            a_d.vec    = vec_tbl[win_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '{iack_prev: 1'b1, active: 1'b0, vec: '0};
        end else begin
            a_q <= a_d;
        end
    end

    assign vec_o   = a_q.active ? a_q.vec : '0;
    assign vec_oe  = a_q.active;
    assign dtack_n = !a_q.active;
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
    import irq_chain_pkg::*;
#(
    parameter int          NUM_SRC  = 9,
    parameter int          PRI_W    = 2,
    parameter logic [7:0]  VEC_BASE = 8'h40,
    localparam int         SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause_i,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_kind,
    input  logic [SRC_W-1:0]   cfg_idx,
    input  logic [7:0]         cfg_wdata,
    input  logic               stat_rd,
    input  logic [SRC_W-1:0]   stat_idx,
    output logic [NUM_SRC-1:0] pend_o,
    input  logic               iack_n,
    input  logic               iei_n,
    output logic               irq_od_n,
    output logic               ieo_n,
    output logic [7:0]         vec_o,
    output logic               vec_oe,
    output logic               dtack_n
);
    logic [NUM_SRC-1:0]             req;
    logic [NUM_SRC-1:0][PRI_W-1:0]  pri;
    logic [NUM_SRC-1:0][VEC_W-1:0]  vec_tbl;
    logic                           any_req;
    logic [SRC_W-1:0]               win_idx;

    irq_src_bank #(
        .NUM_SRC (NUM_SRC),
        .PRI_W   (PRI_W),
        .VEC_BASE(VEC_BASE)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_i  (cause_i),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_idx  (cfg_idx),
        .cfg_wdata(cfg_wdata),
        .stat_rd  (stat_rd),
        .stat_idx (stat_idx),
        .pend_o   (pend_o),
        .req_o    (req),
        .pri_o    (pri),
        .vec_o    (vec_tbl)
    );

    irq_prio_sel #(
        .NUM_SRC(NUM_SRC),
        .PRI_W  (PRI_W)
    ) sel_i (
        .req_i(req),
        .pri_i(pri),
        .any_o(any_req),
        .win_o(win_idx)
    );

    irq_ack_ctl #(
        .NUM_SRC(NUM_SRC)
    ) ack_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .iack_n (iack_n),
        .iei_n  (iei_n),
        .any_req(any_req),
        .win_idx(win_idx),
        .vec_tbl(vec_tbl),
        .vec_o  (vec_o),
        .vec_oe (vec_oe),
        .dtack_n(dtack_n)
    );

    assign irq_od_n = !any_req;
    assign ieo_n    = iei_n || any_req;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int NUM_SRC = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stat_rd,
    input logic [NUM_SRC-1:0] pend_o,
    input logic               iack_n,
    input logic               iei_n,
    input logic               irq_od_n,
    input logic               ieo_n,
    input logic [7:0]         vec_o,
    input logic               dtack_n
);
    // R1
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_rd) |-> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R4
    chain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ieo_n |-> (!iei_n && irq_od_n));

    // R5
    dtack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack_n |=> dtack_n);

    // R5
    answer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(!irq_od_n && !iei_n && !iack_n));

    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && $past(!dtack_n)) |-> $stable(vec_o));

    // R8
    blocked_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(iack_n) && iei_n) |=> dtack_n);
endmodule

bind irq_chain_top irq_chain_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_rd (stat_rd),
    .pend_o  (pend_o),
    .iack_n  (iack_n),
    .iei_n   (iei_n),
    .irq_od_n(irq_od_n),
    .ieo_n   (ieo_n),
    .vec_o   (vec_o),
    .dtack_n (dtack_n)
);

// File: tb/irq_chain_top_tb_top.sv
`timescale 1ns/1ps
module irq_chain_top_tb_top;
    localparam int         NS    = 9;
    localparam int         PW    = 2;
    localparam int         SW    = $clog2(NS);
    localparam logic [7:0] VBASE = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] cause;
    logic          cfg_we;
    logic [1:0]    cfg_kind;
    logic [SW-1:0] cfg_idx;
    logic [7:0]    cfg_wdata;
    logic          stat_rd;
    logic [SW-1:0] stat_idx;
    logic [NS-1:0] pend;
    logic          iack_n, iei_n, irq_od_n, ieo_n, vec_oe, dtack_n;
    logic [7:0]    vec;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] vexp [NS];
    int         pexp [NS];

    always #2 clk = ~clk;

    irq_chain_top #(.NUM_SRC(NS), .PRI_W(PW), .VEC_BASE(VBASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cause_i(cause), .cfg_we(cfg_we),
        .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .stat_rd(stat_rd), .stat_idx(stat_idx), .pend_o(pend),
        .iack_n(iack_n), .iei_n(iei_n), .irq_od_n(irq_od_n), .ieo_n(ieo_n),
        .vec_o(vec), .vec_oe(vec_oe), .dtack_n(dtack_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] k, input int idx, input logic [7:0] d);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = SW'(idx); cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic raise(input logic [NS-1:0] bits);
        cause = bits;
        step();
        cause = '0;
    endtask

    task automatic clear(input int idx);
        stat_rd = 1'b1; stat_idx = SW'(idx);
        step();
        stat_rd = 1'b0;
    endtask

    task automatic ack_expect(input string tag, input logic [7:0] exp_vec);
        iack_n = 1'b0;
        step();
        check({tag, " dtack"}, 32'(dtack_n), 32'd0);
        check({tag, " oe"},    32'(vec_oe),  32'd1);
        check({tag, " vec"},   32'(vec),     32'(exp_vec));
        iack_n = 1'b1;
        step();
        check("R5 release dtack", 32'(dtack_n), 32'd1);
        check("R5 release vec",   {23'd0, vec_oe, vec}, 32'd0);
    endtask

    function automatic int winner(input logic [NS-1:0] bits);
        int w = -1;
        for (int k = 0; k < NS; k++) begin
            if (bits[k] && (w < 0 || pexp[k] > pexp[w])) w = k;
        end
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cause = '0; cfg_we = 1'b0; cfg_kind = '0; cfg_idx = '0;
        cfg_wdata = '0; stat_rd = 1'b0; stat_idx = '0; iack_n = 1'b1; iei_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step();
        // R9 reset state
        check("R9 pend", 32'(pend), 32'd0);
        check("R3 irq idle", 32'(irq_od_n), 32'd1);
        check("R4 ieo idle", 32'(ieo_n), 32'd0);
        check("R5 dtack idle", 32'(dtack_n), 32'd1);

        // R3 disabled pending does not request; R8 ack with no request ignored
        raise(NS'(1) << 2);
        check("R1 pend set", 32'(pend), 32'(1 << 2));
        check("R3 masked", 32'(irq_od_n), 32'd1);
        iack_n = 1'b0;
        step();
        check("R8 no request dtack", 32'(dtack_n), 32'd1);
        iack_n = 1'b1;
        step();
        clear(2);
        check("R2 cleared", 32'(pend), 32'd0);

        // R10 enable all
        for (int i = 0; i < NS; i++) begin
            cfg_write(2'd0, i, 8'h01);
            pexp[i] = 0;
            vexp[i] = VBASE + 8'(i);
        end

        // R9 default vectors, R9 ack keeps pending, R2 clear
        for (int i = 0; i < NS; i++) begin
            raise(NS'(1) << i);
            step(2);
            check("R1 sticky", 32'(pend), 32'(1 << i));
            check("R3 irq low", 32'(irq_od_n), 32'd0);
            check("R4 ieo blocked", 32'(ieo_n), 32'd1);
            ack_expect("R9 default vector", vexp[i]);
            check("R1 ack keeps pending", 32'(pend), 32'(1 << i));
            clear(i);
            check("R2 clear", 32'(pend), 32'd0);
            check("R3 irq released", 32'(irq_od_n), 32'd1);
        end

        // R10 program vectors and priorities
        for (int i = 0; i < NS; i++) begin
            vexp[i] = 8'hA0 ^ 8'(i * 7);
            pexp[i] = (i * 3 + 1) % 4;
            cfg_write(2'd1, i, vexp[i]);
            cfg_write(2'd2, i, 8'(pexp[i]));
        end

        // R6 pair sweep
        for (int i = 0; i < NS; i++) begin
            for (int j = i + 1; j < NS; j++) begin
                logic [NS-1:0] b;
                b = (NS'(1) << i) | (NS'(1) << j);
                raise(b);
                ack_expect("R6 pair", vexp[winner(b)]);
                clear(i);
                clear(j);
            end
        end

        // R6 all sources at once
        raise('1);
        ack_expect("R6 all", vexp[winner('1)]);

        // R2 status read clears only the named source
        clear(4);
        check("R2 named only", 32'(pend), 32'(((1 << NS) - 1) & ~(1 << 4)));
        // R2 out-of-range index clears nothing
        clear(12);
        check("R2 out of range", 32'(pend), 32'(((1 << NS) - 1) & ~(1 << 4)));
        // R2 cause in same cycle wins
        cause = NS'(1) << 5; stat_rd = 1'b1; stat_idx = SW'(5);
        step();
        cause = '0; stat_rd = 1'b0;
        check("R2 set wins", 32'(pend[5]), 32'd1);
        for (int i = 0; i < NS; i++) clear(i);
        check("R2 all cleared", 32'(pend), 32'd0);

        // R7 capture at start; later higher-priority cause does not change vector
        raise(NS'(1) << 1);                   // priority 0
        iack_n = 1'b0;
        step();
        check("R7 first vec", 32'(vec), 32'(vexp[1]));
        raise(NS'(1) << 2);                   // priority 3
        cfg_write(2'd2, 1, 8'd3);
        step(2);
        check("R7 held vec", 32'(vec), 32'(vexp[1]));
        check("R7 held dtack", 32'(dtack_n), 32'd0);
        iack_n = 1'b1;
        step();
        cfg_write(2'd2, 1, 8'(pexp[1]));
        clear(1);
        clear(2);

        // R8 chain blocked upstream
        raise(NS'(1) << 6);
        iei_n = 1'b1;
        step();
        check("R4 ieo with iei high", 32'(ieo_n), 32'd1);
        iack_n = 1'b0;
        step();
        check("R8 blocked dtack", 32'(dtack_n), 32'd1);
        check("R8 blocked oe", 32'(vec_oe), 32'd0);
        iei_n = 1'b0;
        step(2);
        check("R8 no fall no answer", 32'(dtack_n), 32'd1);
        iack_n = 1'b1;
        step();
        ack_expect("R5 after unblock", vexp[6]);
        clear(6);
        check("R4 ieo passes", 32'(ieo_n), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule